// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a purely combinational integer arithmetic and logic unit of configurable width, 32 bits by default. Each evaluation takes two operands, a four-bit operation code and the current carry flag. It returns a result word, a qualifier that says whether the result should be written to a destination, and the next values of the four condition flags: negative, zero, carry and overflow. The flag register itself lives outside the block. The surrounding pipeline latches the flags and decides on the write.

Addition, subtraction, negation and compare all run through one adder. A conditional inverter sits on its second input and the carry-in is forced. Bitwise operations, single-position shifts and rotates through the carry flag each have their own datapath. The compare and test operations only produce flags: their write qualifier is low.

Top module: `alu_core`

## Requirements
- R1: Opcodes on `op_sel` are ADD=0, SUB=1, NEG=2, CMP=3, AND=4, OR=5, XOR=6, NOT=7, TEST=8, SHL=9, SHR=10, SAR=11, ROL=12, ROR=13. The values 14 and 15 are reserved.
- R2: ADD returns the low W bits of A+B. C is the carry out of the MSB, and `carry_in` has no effect on ADD, SUB, NEG, CMP, the logic operations or the shifts.
- R3: SUB and CMP compute A + NOT(B) + 1 on the shared adder. C is the raw carry out, so C=1 means A >= B unsigned (no borrow).
- R4: `flag_n` equals result bit W-1, and `flag_z` is 1 exactly when every result bit is 0, for every opcode.
- R5: For ADD, SUB, NEG and CMP, V is the XOR of the carry into and the carry out of the MSB. Adding operands of opposite sign never sets V.
- R6: `result_we` is 0 for CMP, TEST and the reserved codes, and 1 for all other opcodes. CMP and TEST still drive `result` and the flags.
- R7: AND, OR, XOR, NOT and TEST (TEST is A AND B) clear C and V.
- R8: SHL, SHR and SAR shift by one position. SHL and SHR fill the vacated bit with 0, and SAR copies the sign bit into it. C takes the bit shifted out: bit W-1 for SHL, bit 0 for right shifts. V is 0.
- R9: ROL shifts left by one, puts `carry_in` into bit 0 and puts old bit W-1 into C. ROR shifts right by one, puts `carry_in` into bit W-1 and puts old bit 0 into C. V is 0.
- R10: NEG returns 0 - A. NEG of the most negative value (1 followed by zeros) returns the same pattern with V=1. C is 1 only when A is 0.
- R11: The reserved codes return a zero result with C=0 and V=0, so Z=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_sel | input | 4 | Operation code |
| carry_in | input | 1 | Current carry flag, consumed by rotates |
| result | output | W | Operation result |
| result_we | output | 1 | Result should be written back |
| flag_n | output | 1 | Next negative flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| flag_v | output | 1 | Next overflow flag |

## Verification
The arithmetic vectors pair same-sign and opposite-sign operands, so they show whether V comes from the MSB carries and not from the result sign. Borrow and no-borrow subtractions show whether C has the right polarity. Shift and rotate patterns set both end bits of the operand. This separates fill-with-zero from sign fill and reveals whether the incoming carry enters at the correct end. The corner vectors are negation of zero and of the most negative value, a compare of equal operands, and reserved codes. Each runs with `carry_in` set as well as clear, which shows where the carry must be ignored.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_NEG  = 4'd2,
    OP_CMP  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOT  = 4'd7,
    OP_TEST = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_SAR  = 4'd11,
    OP_ROL  = 4'd12,
    OP_ROR  = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_SHIFT = 2'd2,
    GRP_NONE  = 2'd3
  } alu_grp_e;

  // Datapath group that owns an opcode (R1, R11)
  function automatic alu_grp_e op_group(input logic [3:0] op);
    if (op <= 4'd3)       return GRP_ARITH;
    else if (op <= 4'd8)  return GRP_LOGIC;
    else if (op <= 4'd13) return GRP_SHIFT;
    else                  return GRP_NONE;
  endfunction

  // Write qualifier (R6): compare-style and reserved codes do not write
  function automatic logic op_writes(input logic [3:0] op);
    return !((op == 4'(OP_CMP)) || (op == 4'(OP_TEST)) || (op > 4'd13));
  endfunction

  // Adder needs the inverted second input and a forced carry (R3, R10)
  function automatic logic op_inverts(input logic [3:0] op);
    return (op == 4'(OP_SUB)) || (op == 4'(OP_CMP)) || (op == 4'(OP_NEG));
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out_msb
);
  localparam int LW = W - 1;

  logic         is_neg;
  logic         inv;
  logic [W-1:0] x_in;
  logic [W-1:0] y_sel;
  logic [W-1:0] y_in;
  logic [LW:0]  low_sum;
  logic [1:0]   top_sum;

  always_comb begin
    is_neg  = (op == 4'(OP_NEG));
    inv     = op_inverts(op);
    x_in    = is_neg ? '0 : a;
    y_sel   = is_neg ? a : b;
    y_in    = inv ? ~y_sel : y_sel;
    low_sum = {1'b0, x_in[LW-1:0]} + {1'b0, y_in[LW-1:0]} + {{LW{1'b0}}, inv};
    top_sum = {1'b0, x_in[W-1]} + {1'b0, y_in[W-1]} + {1'b0, low_sum[LW]};
  end

  assign sum        = {top_sum[0], low_sum[LW-1:0]};
  assign c_into_msb = low_sum[LW];
  assign c_out_msb  = top_sum[1];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (op)
        4'(OP_AND), 4'(OP_TEST): res[i] = a[i] & b[i];
        4'(OP_OR):               res[i] = a[i] | b[i];
        4'(OP_XOR):              res[i] = a[i] ^ b[i];
        4'(OP_NOT):              res[i] = ~a[i];
        default:                 res[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    case (op)
      4'(OP_SHL): begin res = {a[W-2:0], 1'b0};    cout = a[W-1]; end
      4'(OP_SHR): begin res = {1'b0, a[W-1:1]};    cout = a[0];   end
      4'(OP_SAR): begin res = {a[W-1], a[W-1:1]};  cout = a[0];   end
      4'(OP_ROL): begin res = {a[W-2:0], cin};     cout = a[W-1]; end
      4'(OP_ROR): begin res = {cin, a[W-1:1]};     cout = a[0];   end
      default:    begin res = '0;                  cout = 1'b0;   end
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_grp_e     grp,
  input  logic [W-1:0] res,
  input  logic         add_c_in_msb,
  input  logic         add_c_out,
  input  logic         shf_c_out,
  output logic         n,
  output logic         z,
  output logic         c,
  output logic         v
);
  always_comb begin
    n = res[W-1];
    z = ~|res;
    case (grp)
      GRP_ARITH: begin c = add_c_out; v = add_c_in_msb ^ add_c_out; end
      GRP_SHIFT: begin c = shf_c_out; v = 1'b0; end
      default:   begin c = 1'b0;      v = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op_sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  alu_grp_e     grp;
  logic [W-1:0] add_sum;
  logic [W-1:0] log_res;
  logic [W-1:0] shf_res;
  logic         add_c_msb;
  logic         add_c_out;
  logic         shf_c_out;

  assign grp       = op_group(op_sel);
  assign result_we = op_writes(op_sel);

  alu_addsub #(.W(W)) u_addsub (
    .op(op_sel), .a(opnd_a), .b(opnd_b),
    .sum(add_sum), .c_into_msb(add_c_msb), .c_out_msb(add_c_out)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op_sel), .a(opnd_a), .b(opnd_b), .res(log_res)
  );

  alu_shift #(.W(W)) u_shift (
    .op(op_sel), .a(opnd_a), .cin(carry_in), .res(shf_res), .cout(shf_c_out)
  );

  always_comb begin
    case (grp)
      GRP_ARITH: result = add_sum;
      GRP_LOGIC: result = log_res;
      GRP_SHIFT: result = shf_res;
      default:   result = '0;
    endcase
  end

  alu_flags #(.W(W)) u_flags (
    .grp(grp), .res(result),
    .add_c_in_msb(add_c_msb), .add_c_out(add_c_out), .shf_c_out(shf_c_out),
    .n(flag_n), .z(flag_z), .c(flag_c), .v(flag_v)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   op_sel,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic         flag_c,
  input logic         flag_v,
  input logic         add_c_msb,
  input logic         add_c_out
);
  logic is_logic;
  assign is_logic = (op_sel >= 4'd4) && (op_sel <= 4'd8);

  always_comb begin
    // R6: compare-style opcodes never request a write
    if ((op_sel == 4'(OP_CMP)) || (op_sel == 4'(OP_TEST)))
      a_r6_cmp_no_write: assert (!result_we);
    // R5: opposite-sign addition never overflows
    if ((op_sel == 4'(OP_ADD)) && (opnd_a[W-1] != opnd_b[W-1]))
      a_r5_no_overflow: assert (!flag_v);
    // R5: overflow on the adder is the carry mismatch at the MSB
    if (op_sel <= 4'd3)
      a_r5_v_from_carries: assert (flag_v == (add_c_msb != add_c_out));
    // R3: subtract carry is the unsigned no-borrow indication
    if ((op_sel == 4'(OP_SUB)) || (op_sel == 4'(OP_CMP)))
      a_r3_no_borrow: assert (flag_c == (opnd_a >= opnd_b));
    // R7: logic operations clear carry and overflow
    if (is_logic)
      a_r7_logic_cv_clear: assert (!flag_c && !flag_v);
    // R9: rotate left brings the carry into bit 0
    if (op_sel == 4'(OP_ROL))
      a_r9_rol_through_c: assert (result[0] == carry_in && flag_c == opnd_a[W-1]);
    // R11: reserved codes produce nothing
    if (op_sel > 4'd13)
      a_r11_reserved_quiet: assert (result == '0 && !result_we && !flag_c);
  end

endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .carry_in(carry_in),
  .result(result), .result_we(result_we), .flag_c(flag_c), .flag_v(flag_v),
  .add_c_msb(add_c_msb), .add_c_out(add_c_out)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NV = 25;

  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic [31:0] res;
    logic        we;
    logic [3:0]  nzcv;
  } vec_t;

  // Opcode codes from R1; nzcv packs N,Z,C,V msb first
  localparam vec_t VECS [NV] = '{
    '{"R2 ", 4'd0,  32'h0000_0003, 32'h0000_0004, 1'b0, 32'h0000_0007, 1'b1, 4'b0000},
    '{"R5 ", 4'd0,  32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b1, 4'b1001},
    '{"R2 ", 4'd0,  32'hFFFF_FFFC, 32'h0000_0004, 1'b0, 32'h0000_0000, 1'b1, 4'b0110},
    '{"R5 ", 4'd0,  32'hFFFF_FFFC, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFB, 1'b1, 4'b1010},
    '{"R3 ", 4'd1,  32'h0000_0002, 32'h0000_0007, 1'b0, 32'hFFFF_FFFB, 1'b1, 4'b1000},
    '{"R3 ", 4'd1,  32'h0000_0007, 32'h0000_0002, 1'b0, 32'h0000_0005, 1'b1, 4'b0010},
    '{"R5 ", 4'd1,  32'h8000_0000, 32'h0000_0001, 1'b0, 32'h7FFF_FFFF, 1'b1, 4'b0011},
    '{"R6 ", 4'd3,  32'h0000_0005, 32'h0000_0005, 1'b0, 32'h0000_0000, 1'b0, 4'b0110},
    '{"R10", 4'd2,  32'h8000_0000, 32'h0000_0000, 1'b0, 32'h8000_0000, 1'b1, 4'b1001},
    '{"R10", 4'd2,  32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1, 4'b0110},
    '{"R10", 4'd2,  32'h0000_0012, 32'h0000_0000, 1'b0, 32'hFFFF_FFEE, 1'b1, 4'b1000},
    '{"R7 ", 4'd4,  32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 32'hF000_F000, 1'b1, 4'b1000},
    '{"R7 ", 4'd5,  32'h0000_000F, 32'h0000_00F0, 1'b0, 32'h0000_00FF, 1'b1, 4'b0000},
    '{"R4 ", 4'd6,  32'hAAAA_5555, 32'hAAAA_5555, 1'b0, 32'h0000_0000, 1'b1, 4'b0100},
    '{"R7 ", 4'd7,  32'h0000_0000, 32'h1234_5678, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'b1000},
    '{"R6 ", 4'd8,  32'h0000_000F, 32'h0000_00F0, 1'b0, 32'h0000_0000, 1'b0, 4'b0100},
    '{"R8 ", 4'd9,  32'h8000_0001, 32'h0000_0000, 1'b0, 32'h0000_0002, 1'b1, 4'b0010},
    '{"R8 ", 4'd10, 32'h8000_0001, 32'h0000_0000, 1'b1, 32'h4000_0000, 1'b1, 4'b0010},
    '{"R8 ", 4'd11, 32'h8000_0001, 32'h0000_0000, 1'b0, 32'hC000_0000, 1'b1, 4'b1010},
    '{"R9 ", 4'd12, 32'h8000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b1, 4'b0010},
    '{"R9 ", 4'd13, 32'h0000_0001, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1, 4'b0110},
    '{"R9 ", 4'd13, 32'h0000_0002, 32'h0000_0000, 1'b1, 32'h8000_0001, 1'b1, 4'b1000},
    '{"R2 ", 4'd0,  32'h0000_0003, 32'h0000_0004, 1'b1, 32'h0000_0007, 1'b1, 4'b0000},
    '{"R11", 4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 4'b0100},
    '{"R8 ", 4'd9,  32'h0000_0001, 32'h0000_0000, 1'b1, 32'h0000_0002, 1'b1, 4'b0000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [3:0]   op_sel = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         result_we;
  logic         flag_n, flag_z, flag_c, flag_v;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core #(.W(W)) u_dut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .carry_in(carry_in),
    .result(result), .result_we(result_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic apply_check(input vec_t v);
    @(posedge clk);
    opnd_a   = v.a;
    opnd_b   = v.b;
    op_sel   = v.op;
    carry_in = v.cin;
    @(negedge clk);
    n_tests++;
    if (result !== v.res || result_we !== v.we ||
        {flag_n, flag_z, flag_c, flag_v} !== v.nzcv) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%b: got res=%h we=%b nzcv=%b, expected res=%h we=%b nzcv=%b",
               v.tag, v.op, v.a, v.b, v.cin, result, result_we,
               {flag_n, flag_z, flag_c, flag_v}, v.res, v.we, v.nzcv);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog expired: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state after reset: all-zero inputs decode as ADD 0+0 (R4, R2)
    @(negedge clk);
    n_tests++;
    if (result !== '0 || result_we !== 1'b1 ||
        {flag_n, flag_z, flag_c, flag_v} !== 4'b0100) begin
      n_fail++;
      $display("FAIL R4 idle: got res=%h we=%b nzcv=%b, expected res=0 we=1 nzcv=0100",
               result, result_we, {flag_n, flag_z, flag_c, flag_v});
    end

    for (int i = 0; i < NV; i++) apply_check(VECS[i]);

    // R5: two large positives overflow to negative, carry clear
    apply_check('{"R5 ", 4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0,
                  32'hFFFF_FFFE, 1'b1, 4'b1001});
    // R10: most negative value negates to itself, carry-in set must not matter
    apply_check('{"R10", 4'd2, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1,
                  32'h8000_0000, 1'b1, 4'b1001});
    // R11: second reserved code
    apply_check('{"R11", 4'd15, 32'h1234_5678, 32'h0000_0001, 1'b0,
                  32'h0000_0000, 1'b0, 4'b0100});
    // R6: CMP with borrow still drives the difference and flags
    apply_check('{"R6 ", 4'd3, 32'h0000_0001, 32'h0000_0002, 1'b1,
                  32'hFFFF_FFFF, 1'b0, 4'b1000});
    // R1: SUB code with carry set behaves as SUB, not ADD
    apply_check('{"R1 ", 4'd1, 32'h0000_0000, 32'h0000_0001, 1'b1,
                  32'hFFFF_FFFF, 1'b1, 4'b1000});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule